// File: doc/BRIEF.md
# Two-Counter PWM Timer

This block is a timer with two counters behind a small register interface. Each counter has its own control word, a load value and a count that can be read back. Each counter can count up or down and can be preloaded from its load value. At the end of every cycle it can reload itself. When both counters are set up for waveform generation, they drive one active-high PWM output. Counter 0 sets the length of each period. Counter 1 sets how long the output stays high at the start of each period.

Software writes the load values and then holds the load bit in both control words to move those values into the counters. It then starts both counters together with one control write that sets the enable-all bit. After that, new load values take effect only at the next reload, so the waveform can be changed while the output is running. The interface is one 32-bit write port and a combinational read port on byte addresses. It has no wait states and no handshake.

Top module: `dual_counter_pwm`

## Requirements
- R1: After a synchronous reset every control word, load value and count reads 0, and `pwm_out` is low.
- R2: The register offsets are: control 0 at 0x00, load 0 at 0x04, count 0 at 0x08, control 1 at 0x10, load 1 at 0x14, count 1 at 0x18. Any other address reads 0. Writes to the count offsets have no effect. Load registers keep only the low CNT_W bits of the write data. The control bits are: 0 mode (0 selects generate), 1 direction (1 = down), 2 output enable, 4 auto-reload, 5 load, 7 run, 9 PWM enable, 10 enable-all, 11 cascade. All other control bits read 0.
- R3: While the load bit is set, the counter takes the value its load register held on the previous clock, and it does not count.
- R4: A running counter that counts down steps from L to 0, shows all ones for one clock, then reloads, so its cycle is L+2 clocks. A running counter that counts up steps from L to all ones, shows 0 for one clock, then reloads, so its cycle is (2^CNT_W-1-L)+2 clocks.
- R5: With auto-reload clear, a running counter stops at its terminal value: 0 when counting down, all ones when counting up.
- R6: A control write with bit 10 set sets the run bit of both counters on the same clock. Bit 10 reads 1 whenever either counter is running.
- R7: A load value written while the counter runs does not change the count until the counter's next reload.
- R8: PWM is active only when both counters have mode 0, output enable, auto-reload, run and PWM enable set and the load bit clear, and counter 0 also has cascade clear. When these conditions fail, `pwm_out` is low from the next clock on.
- R9: In PWM mode `pwm_out` rises when counter 0 reloads. It stays high for counter 1's cycle length and then falls, so the output repeats with counter 0's cycle length.
- R10: If counter 1's cycle length is equal to or greater than counter 0's, `pwm_out` stays low.
- R11: In PWM mode counter 1 is reloaded from its load register whenever counter 0 reloads, whatever count it has reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 5 | Byte address of the register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| pwm_out | output | 1 | Active-high PWM output |

## Verification
Counting is tried in both directions with several load values. This shows the two-clock overhead and the terminal wrap value, and it separates a reload taken at the cycle boundary from one taken at once. In the PWM run, counter 0's cycle of 7 is chosen so that it is not a multiple of counter 1's cycle of 3. Only the forced restart of counter 1 at each period boundary then gives the expected count. The high/low pattern pins down both the rising edge and the falling edge. Further runs use a high time equal to the period, a high time one clock shorter than the period, and a PWM enable bit cleared while the output is high. These show the constant-low rule, the normal duty count and the forced low.

// File: rtl/dual_counter_pwm.sv
module dual_counter_pwm #(
  parameter int CNT_W = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [4:0]  addr,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        pwm_out
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};
  localparam logic [11:0] CSR_MASK = 12'hAB7;

  logic [11:0]      csr [2];
  logic [CNT_W-1:0] ld  [2];
  logic [CNT_W-1:0] cnt [2];
  logic [1:0]       rl;
  logic             pwm_q;

  function automatic logic gen_ok(input logic [11:0] c);
    return !c[0] && c[2] && c[4] && !c[5] && c[7] && c[9];
  endfunction

  function automatic logic [CNT_W:0] cyc_len(input logic [CNT_W-1:0] l, input logic down);
    return down ? ({1'b0, l} + (CNT_W+1)'(2))
                : ({1'b0, MAXV} - {1'b0, l} + (CNT_W+1)'(2));
  endfunction

  logic [1:0] hit_csr, hit_ld;
  assign hit_csr = {addr == 5'h10, addr == 5'h00};
  assign hit_ld  = {addr == 5'h14, addr == 5'h04};

  logic act, p0, hi_ok, en_any;
  assign act    = gen_ok(csr[0]) && !csr[0][11] && gen_ok(csr[1]);
  assign p0     = act && rl[0];
  assign hi_ok  = cyc_len(ld[1], csr[1][1]) < cyc_len(ld[0], csr[0][1]);
  assign en_any = csr[0][7] || csr[1][7];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 2; i++) begin
        csr[i] <= '0;
        ld[i]  <= '0;
        cnt[i] <= '0;
      end
      rl    <= '0;
      pwm_q <= 1'b0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (csr[i][5]) begin
          cnt[i] <= ld[i];
          rl[i]  <= 1'b0;
        end else if (i == 1 && p0) begin
          cnt[i] <= ld[i];
          rl[i]  <= 1'b0;
        end else if (csr[i][7]) begin
          if (rl[i]) begin
            cnt[i] <= ld[i];
            rl[i]  <= 1'b0;
          end else if (cnt[i] == (csr[i][1] ? '0 : MAXV)) begin
            if (csr[i][4]) begin
              cnt[i] <= csr[i][1] ? MAXV : '0;
              rl[i]  <= 1'b1;
            end
          end else begin
            cnt[i] <= csr[i][1] ? cnt[i] - 1'b1 : cnt[i] + 1'b1;
          end
        end
        if (wr_en && hit_csr[i]) csr[i] <= wr_data[11:0] & CSR_MASK;
        if (wr_en && hit_ld[i])  ld[i]  <= wr_data[CNT_W-1:0];
      end
      if (wr_en && |hit_csr && wr_data[10]) begin
        csr[0][7] <= 1'b1;
        csr[1][7] <= 1'b1;
      end
      if (!act)        pwm_q <= 1'b0;
      else if (p0)     pwm_q <= hi_ok;
      else if (rl[1])  pwm_q <= 1'b0;
    end
  end

  assign pwm_out = pwm_q;

  always_comb begin
    case (addr)
      5'h00:   rd_data = {20'b0, csr[0][11], en_any, csr[0][9:0]};
      5'h04:   rd_data = 32'(ld[0]);
      5'h08:   rd_data = 32'(cnt[0]);
      5'h10:   rd_data = {20'b0, csr[1][11], en_any, csr[1][9:0]};
      5'h14:   rd_data = 32'(ld[1]);
      5'h18:   rd_data = 32'(cnt[1]);
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/dual_counter_pwm_chk.sv
module dual_counter_pwm_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [4:0]       addr,
  input logic             wr_bit10,
  input logic             pwm_out,
  input logic             act,
  input logic [11:0]      csr0,
  input logic [11:0]      csr1,
  input logic [CNT_W-1:0] cnt0,
  input logic [CNT_W-1:0] ld0,
  input logic             rl0
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  p_idle_low_r8: assert property (@(posedge clk) disable iff (rst)
    !act |=> !pwm_out);

  p_rise_at_reload_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(pwm_out) |-> $past(rl0));

  p_load_copy_r3: assert property (@(posedge clk) disable iff (rst)
    csr0[5] |=> cnt0 == $past(ld0));

  p_enall_both_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (addr == 5'h00 || addr == 5'h10) && wr_bit10) |=> (csr0[7] && csr1[7]));

  p_down_step_r4: assert property (@(posedge clk) disable iff (rst)
    (csr0[7] && !csr0[5] && csr0[1] && !rl0 && cnt0 != '0) |=> cnt0 == $past(cnt0) - 1'b1);

  p_stop_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (csr0[7] && !csr0[5] && !csr0[4] && !rl0 && cnt0 == (csr0[1] ? '0 : MAXV))
      |=> cnt0 == $past(cnt0));
endmodule

bind dual_counter_pwm dual_counter_pwm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_bit10(wr_data[10]),
  .pwm_out(pwm_out), .act(act), .csr0(csr[0]), .csr1(csr[1]),
  .cnt0(cnt[0]), .ld0(ld[0]), .rl0(rl[0])
);

// File: tb/dual_counter_pwm_bench.sv
`timescale 1ns/1ps
module dual_counter_pwm_bench;
  logic clk = 1'b0;
  logic rst, wr_en;
  logic [4:0] addr;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic pwm_out;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  typedef struct {
    bit is_pwm;
    logic [31:0] exp;
    string tag;
  } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  dual_counter_pwm #(.CNT_W(8)) u_dual_counter_pwm (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .pwm_out(pwm_out)
  );

  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] got;
      it = q.pop_front();
      got = it.is_pwm ? {31'b0, pwm_out} : rd_data;
      checks++;
      if (got !== it.exp) begin
        fails++;
        $display("FAIL %s actual %h expected %h", it.tag, got, it.exp);
      end
    end
  end

  task automatic cyc(input bit w, input logic [4:0] a, input logic [31:0] d);
    @(posedge clk);
    #1;
    wr_en = w;
    addr = a;
    wr_data = d;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string tag);
    cyc(0, a, 0);
    q.push_back('{1'b0, e, tag});
  endtask

  task automatic pw(input bit e, input string tag);
    q.push_back('{1'b1, {31'b0, e}, tag});
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #(5 * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    int highs;
    int exp_list[$];
    rst = 1'b1; wr_en = 1'b0; addr = '0; wr_data = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    rd(5'h00, 0, "R1 csr0"); pw(0, "R1 pwm");
    rd(5'h04, 0, "R1 load0");
    rd(5'h08, 0, "R1 count0");
    rd(5'h10, 0, "R1 csr1");
    rd(5'h14, 0, "R1 load1");
    rd(5'h18, 0, "R1 count1");

    // R2 register map and masking
    cyc(1, 5'h10, 32'hFFFF_FBFF);
    rd(5'h10, 32'h0000_0EB7, "R2 csr1 mask");
    cyc(1, 5'h10, 0);
    rd(5'h10, 0, "R2 csr1 cleared");
    cyc(1, 5'h08, 32'h33);
    rd(5'h08, 0, "R2 count read-only");
    rd(5'h1C, 0, "R2 unused address");
    cyc(1, 5'h14, 32'hABCD_1234);
    rd(5'h14, 32'h34, "R2 load width");

    // R4 down count, then R7 late load
    cyc(1, 5'h04, 3);
    cyc(1, 5'h00, 32'h22);
    cyc(1, 5'h00, 32'h92);
    exp_list = '{3, 2, 1, 0, 255, 3, 2};
    foreach (exp_list[i]) rd(5'h08, exp_list[i], "R4 down sequence");
    cyc(1, 5'h04, 6);
    exp_list = '{0, 255, 6, 5};
    foreach (exp_list[i]) rd(5'h08, exp_list[i], "R7 reload at boundary");
    cyc(1, 5'h00, 0);

    // R4 up count
    cyc(1, 5'h04, 252);
    cyc(1, 5'h00, 32'h20);
    cyc(1, 5'h00, 32'h90);
    exp_list = '{252, 253, 254, 255, 0, 252, 253};
    foreach (exp_list[i]) rd(5'h08, exp_list[i], "R4 up sequence");

    // R3 load bit copies load register
    cyc(1, 5'h00, 32'h20);
    cyc(1, 5'h04, 32'h44);
    cyc(0, 5'h08, 0);
    rd(5'h08, 32'h44, "R3 load copy");
    rd(5'h08, 32'h44, "R3 held");
    cyc(1, 5'h00, 0);

    // R5 stop at terminal without auto-reload
    cyc(1, 5'h14, 2);
    cyc(1, 5'h10, 32'h22);
    cyc(1, 5'h10, 32'h82);
    exp_list = '{2, 1, 0, 0, 0};
    foreach (exp_list[i]) rd(5'h18, exp_list[i], "R5 stop at zero");

    // R6, R9, R11, R8 PWM run
    cyc(1, 5'h04, 5);
    cyc(1, 5'h14, 1);
    cyc(1, 5'h00, 32'h20);
    cyc(1, 5'h10, 32'h20);
    cyc(1, 5'h00, 32'h216);
    cyc(1, 5'h10, 32'h696);
    for (int k = 2; k <= 25; k++) begin
      bit e;
      if (k == 2) rd(5'h00, 32'h696, "R6 enable-all readback");
      else if (k == 16) cyc(1, 5'h10, 32'h096);
      else cyc(0, 5'h18, 0);
      if (k == 9) q.push_back('{1'b0, 32'd1, "R11 restart at period"});
      if (k == 10) q.push_back('{1'b0, 32'd0, "R11 count after restart"});
      e = (k >= 9 && k <= 11) || (k == 16) || (k == 17);
      pw(e, (k >= 18) ? "R8 forced low" : "R9 waveform");
    end

    // R10 high time equal to period
    cyc(1, 5'h14, 5);
    cyc(1, 5'h10, 32'h296);
    for (int k = 0; k < 22; k++) begin
      cyc(0, 5'h18, 0);
      pw(0, "R10 constant low");
    end

    // R9 duty count with high time 6 of 7
    cyc(1, 5'h14, 4);
    repeat (8) cyc(0, 5'h00, 0);
    highs = 0;
    for (int k = 0; k < 14; k++) begin
      cyc(0, 5'h00, 0);
      highs += int'(pwm_out);
    end
    checks++;
    if (highs != 12) begin
      fails++;
      $display("FAIL R9 high count actual %0d expected %0d", highs, 12);
    end

    @(negedge clk);
    @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule